// File: doc/BRIEF.md
# Synchronous Bus Single-Word Read Master

This block is a clocked bus master that turns a single-word read request from a local requester into a fixed-schedule transaction on a synchronous memory bus. The bus has no data handshake: the slave drives valid data a known number of cycles after the master raises its read strobe and keeps it there for a known number of cycles after the strobe drops. The master therefore times every phase with one down-counter and samples the data lines in one exact cycle.

A transaction runs through four phases. In the idle phase the block accepts a request (valid and ready both high). In the setup phase it places the address with the strobe low. In the strobe phase it raises READ until the data word is captured. In the hold phase the strobe is low but the slave may still drive the data lines. The captured word is returned with a one-cycle done pulse at the start of the hold phase. A request that arrives during a transaction waits with ready low until the hold window ends.

Top module: `sbus_read_master`

## Requirements
- R1: While reset is held (synchronous, active low) and in the first cycle after it, `bus_read` and `rsp_valid` are low and `req_ready` is high.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. In the cycle after that edge, `bus_addr` carries the accepted address and `bus_read` is still low.
- R3: `bus_read` goes high in the second cycle after acceptance and stays high for exactly DATA_LAT+1 cycles (5 with defaults), so it covers the cycle in which data first becomes valid, DATA_LAT cycles after the strobe rises.
- R4: The word on `bus_data` in the last strobe cycle is captured. In the next cycle `rsp_valid` is high for exactly one cycle, `rsp_data` equals that word, and `bus_read` is low.
- R5: `bus_addr` does not change from the setup cycle until `bus_read` falls.
- R6: For HOLD_CYC cycles after `bus_read` falls (2 with defaults), `req_ready` and `bus_read` stay low. `req_ready` is high again in the next cycle.
- R7: `req_ready` is high exactly when no transaction is in progress. A request held with `req_valid` high while busy is not lost and not accepted early: it is accepted at the first edge where `req_ready` is high.
- R8: Back-to-back requests are accepted every SETUP_CYC+DATA_LAT+1+HOLD_CYC+1 cycles (9 with defaults).
- R9: `req_addr` is sampled only at acceptance. Changing it later has no effect, and `bus_addr` keeps the accepted address until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Requester has a read request |
| req_addr | input | AW | Address of the requested word |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the read word |
| rsp_data | output | DW | Captured data word |
| bus_addr | output | AW | Address lines of the synchronous bus |
| bus_read | output | 1 | READ strobe of the synchronous bus |
| bus_data | input | DW | Data lines driven by the bus slave |

## Verification
A phase counter that is off by one shows up at the bus pins within one transaction. The strobe is one cycle too long or too short. The done pulse moves away from the strobe's falling edge. The captured word is the slave's poison value instead of the address-derived pattern, because the bench slave drives real data only inside the legal window. A phase register stuck outside idle shows up as `req_ready` staying low at the ninth cycle after acceptance. Sweeping every address, both with idle gaps and back-to-back, means any address-dependent or sequencing fault changes a port value within the transaction where it occurs.

// File: rtl/sbus_rd_pkg.sv
// Shared types for the synchronous bus read master.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package sbus_rd_pkg;

    // Transaction phases, in the order a read walks through them.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    // Bits needed to hold a down-counter start value of maxv.
    function automatic int cnt_width(input int maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/sbus_phase_timer.sv
// Down-counter that times one bus phase.
// A load sets the count. The count then falls by one per cycle and stops at
// zero. The expired flag is high while the count is zero, so a load value of
// N gives a phase N+1 cycles long.
// Assumes load_val fits in CW bits.
module sbus_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Load a new phase length, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sbus_rd_capture.sv
// Data capture stage for the read master.
// Latches the bus data word when cap_en is high and raises a one-cycle done
// pulse in the following cycle. The word is held until the next capture.
// Assumes cap_en is never high in two consecutive cycles.
module sbus_rd_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] bus_data,
    output logic [DW-1:0] word_q,
    output logic          done_q
);

    // Hold the sampled word until the next capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (cap_en) begin
            word_q <= bus_data;
        end
    end

    // Done pulse follows the capture edge by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= cap_en;
        end
    end

endmodule

// File: rtl/sbus_read_master.sv
// Single-word read master for a synchronous bus with fixed cycle timing.
// Accepts a request (valid and ready both high) and then runs four phases:
//   setup  : address on the bus, READ low, SETUP_CYC cycles
//   strobe : READ high until the data word is captured, DATA_LAT+1 cycles
//   hold   : READ low while the slave still drives data, HOLD_CYC cycles
//   idle   : ready for the next request
// Assumes SETUP_CYC >= 1 and HOLD_CYC >= 1. Assumes the slave drives valid
// data from DATA_LAT cycles after READ rises until HOLD_CYC cycles after it
// falls.
module sbus_read_master
    import sbus_rd_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int SETUP_CYC = 1,
    parameter int DATA_LAT  = 4,
    parameter int HOLD_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] bus_addr,
    output logic          bus_read,
    input  logic [DW-1:0] bus_data
);

    localparam int SETUP_LD = SETUP_CYC - 1;
    localparam int HOLD_LD  = HOLD_CYC - 1;
    localparam int MAX_LD   = (DATA_LAT > SETUP_LD) ?
                              ((DATA_LAT > HOLD_LD) ? DATA_LAT : HOLD_LD) :
                              ((SETUP_LD > HOLD_LD) ? SETUP_LD : HOLD_LD);
    localparam int CW       = cnt_width(MAX_LD);

    phase_e        phase_q, phase_nxt;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          cap_en;
    logic          accept;
    logic [AW-1:0] addr_q;

    assign accept = (phase_q == PH_IDLE) && req_valid;

    // Phase sequencing: each phase ends when the timer reaches zero.
    always_comb begin
        phase_nxt = phase_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cap_en    = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    phase_nxt = PH_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(SETUP_LD);
                end
            end
            PH_SETUP: begin
                if (tmr_done) begin
                    phase_nxt = PH_STROBE;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(DATA_LAT);
                end
            end
            PH_STROBE: begin
                if (tmr_done) begin
                    cap_en    = 1'b1;
                    phase_nxt = PH_HOLD;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(HOLD_LD);
                end
            end
            PH_HOLD: begin
                if (tmr_done) begin
                    phase_nxt = PH_IDLE;
                end
            end
            default: phase_nxt = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_nxt;
        end
    end

    // Address register: sampled only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
        end
    end

    sbus_phase_timer #(
        .CW(CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sbus_rd_capture #(
        .DW(DW)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .bus_data (bus_data),
        .word_q   (rsp_data),
        .done_q   (rsp_valid)
    );

    assign req_ready = (phase_q == PH_IDLE);
    assign bus_read  = (phase_q == PH_STROBE);
    assign bus_addr  = addr_q;

    // R2
    setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_read) |-> $past(!req_ready));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_read |-> $stable(bus_addr));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4
    done_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $fell(bus_read));

    // R6
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_read) |=> (!bus_read && !req_ready));

    // R7
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_read && !rsp_valid));

endmodule

// File: tb/tb_sbus_read_master.sv
// Bench for the synchronous bus read master. Uses a 6-bit address so that
// every address is read, once with idle gaps and once back-to-back.
// Contains a slave model that drives real data only inside the legal window.
module tb_sbus_read_master;

    localparam int TB_AW = 6;
    localparam int TB_DW = 32;
    localparam int NADDR = 1 << TB_AW;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic [TB_AW-1:0] req_addr;
    logic             req_ready;
    logic             rsp_valid;
    logic [TB_DW-1:0] rsp_data;
    logic [TB_AW-1:0] bus_addr;
    logic             bus_read;
    logic [TB_DW-1:0] bus_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    sbus_read_master #(
        .AW(TB_AW),
        .DW(TB_DW)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .bus_addr  (bus_addr),
        .bus_read  (bus_read),
        .bus_data  (bus_data)
    );

    // Word stored at each address of the model memory.
    function automatic logic [31:0] mem_word(input logic [TB_AW-1:0] a);
        return ((32'(a) + 32'd1) * 32'h9E37_79B9) ^ {26'h0, a};
    endfunction

    // Slave model: data valid from 4 cycles after READ rises until 2 cycles after it falls.
    logic [2:0] hi_cnt;
    logic [1:0] post_cnt;
    logic       seen;
    logic       slv_valid;
    always @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt   <= 3'd0;
            post_cnt <= 2'd3;
            seen     <= 1'b0;
        end else if (bus_read) begin
            if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
            seen     <= (hi_cnt >= 3'd4);
            post_cnt <= 2'd0;
        end else begin
            hi_cnt <= 3'd0;
            if (post_cnt != 2'd3) post_cnt <= post_cnt + 2'd1;
        end
    end
    assign slv_valid = (bus_read && hi_cnt >= 3'd4) || (!bus_read && seen && post_cnt < 2'd2);
    assign bus_data  = slv_valid ? mem_word(bus_addr) : 32'hDEAD_C0DE;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // One read of address a, starting at a negedge where the block is idle.
    task automatic run_one(input int a, input bit b2b, input int nxt);
        logic [TB_AW-1:0] av;
        av = TB_AW'(a);
        req_valid = 1'b1;
        req_addr  = av;
        chk(req_ready === 1'b1, "R7", "ready before accept", 64'(req_ready), 64'd1);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req_valid = b2b;
                req_addr  = b2b ? TB_AW'(nxt) : ~av;
            end
            if (k == 1) begin
                chk(bus_addr === av, "R2", "address placed", 64'(bus_addr), 64'(av));
                chk(bus_read === 1'b0, "R2", "strobe low in setup", 64'(bus_read), 64'd0);
            end else if (k <= 6) begin
                chk(bus_read === 1'b1, "R3", "strobe high", 64'(bus_read), 64'd1);
                chk(bus_addr === av, "R5", "address stable", 64'(bus_addr), 64'(av));
            end else begin
                chk(bus_read === 1'b0, "R6", "strobe low in hold", 64'(bus_read), 64'd0);
            end
            chk(req_ready === 1'b0, "R7", "ready low while busy", 64'(req_ready), 64'd0);
            chk(rsp_valid === (k == 7), "R4", "done pulse", 64'(rsp_valid), 64'(k == 7));
            if (k == 7)
                chk(rsp_data === mem_word(av), "R4", "read word", 64'(rsp_data), 64'(mem_word(av)));
            if (k == 8)
                chk(bus_addr === av, "R9", "address kept after strobe", 64'(bus_addr), 64'(av));
        end
        @(negedge clk);
        chk(req_ready === 1'b1 && bus_read === 1'b0, "R8", "idle after hold",
            64'({req_ready, bus_read}), 64'b10);
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_addr  = '0;
        repeat (3) @(negedge clk);
        chk(bus_read === 1'b0 && rsp_valid === 1'b0 && req_ready === 1'b1, "R1", "in reset",
            64'({bus_read, rsp_valid, req_ready}), 64'b001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_read === 1'b0 && rsp_valid === 1'b0 && req_ready === 1'b1, "R1", "after reset",
            64'({bus_read, rsp_valid, req_ready}), 64'b001);
        // Pass 1: idle gaps of 0 to 2 cycles between reads.
        for (int a = 0; a < NADDR; a++) begin
            for (int g = 0; g < a % 3; g++) begin
                chk(req_ready === 1'b1 && bus_read === 1'b0 && rsp_valid === 1'b0, "R7",
                    "quiet idle", 64'({req_ready, bus_read, rsp_valid}), 64'b100);
                @(negedge clk);
            end
            run_one(a, 1'b0, 0);
        end
        // Pass 2: the next request is held during each read (R7, R8).
        for (int a = NADDR - 1; a >= 0; a--) begin
            run_one(a, a != 0, (a + 37) % NADDR);
        end
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && bus_read === 1'b0, "R7", "no stray read",
            64'({req_ready, bus_read}), 64'b10);
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule